// File: doc/BRIEF.md
# Binary64 Minimum Unit

This block returns the smaller of two IEEE-754 binary64 values with the ordering rules of a managed-language `min()` operation. Each operand is the low 64 bits of a 128-bit vector-register input. The selected value goes to the low 64 bits of a 128-bit result, and the upper 64 bits of the result are always zero.

NaN operands are passed through unchanged, and the first operand's NaN takes precedence. A signalling NaN keeps its quiet bit clear. A separate flag still reports that a signalling NaN was seen. Negative zero orders below positive zero. No rounding takes place, so the unit produces no result-class, rounding or inexact status.

The unit is a single registered stage. A pair of operands presented with `in_valid` high appears on `result` and `snan_flag` at the next rising clock edge, and `out_valid` marks that cycle. When `in_valid` is low, the registered outputs hold their previous values.

Top module: `fp_min_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `out_valid` at 0, `result` all zeros and `snan_flag` at 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. `result` and `snan_flag` load only at edges where `in_valid` is 1, and otherwise keep their value.
- R3: `result[127:64]` is always zero.
- R4: Only `src_a[63:0]` and `src_b[63:0]` are operands. Bits 127:64 of both inputs have no effect on any output.
- R5: If operand A is a NaN (exponent bits 62:52 all ones, fraction bits 51:0 nonzero), `result[63:0]` is A bit-for-bit, whatever B is.
- R6: If A is not a NaN and B is a NaN, `result[63:0]` is B bit-for-bit.
- R7: A signalling NaN (all-ones exponent, bit 51 clear, nonzero fraction) is returned without setting bit 51. `snan_flag` is 1 exactly when at least one operand is a signalling NaN; a quiet NaN (bit 51 set) alone leaves it 0.
- R8: When one operand is +0 (all zeros) and the other is -0 (only bit 63 set), in either order, the result is -0 (0x8000000000000000).
- R9: For two non-NaN operands of opposite sign (bit 63), the result is the negative operand. This covers infinities and subnormals.
- R10: For two non-NaN operands of the same sign, the result is the one with the smaller magnitude (bits 62:0) when both are positive, and the larger magnitude when both are negative. Subnormals and infinities follow the same integer ordering.
- R11: When the two operands are bit-identical and not NaN, such as both +infinity or both -infinity, the result is that common value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| src_a | input | 128 | First vector input; the low 64 bits are operand A |
| src_b | input | 128 | Second vector input; the low 64 bits are operand B |
| out_valid | output | 1 | Result was loaded at the last edge |
| result | output | 128 | Minimum in bits 63:0; bits 127:64 are zero |
| snan_flag | output | 1 | At least one operand was a signalling NaN |

## Verification
The hardest cases to reach are the two NaN priorities together with the signalling flag. Random binary64 patterns almost never land on an all-ones exponent, and a signalling NaN in particular needs bit 51 clear with the rest of the fraction nonzero. The stimulus therefore builds these encodings directly. It pairs signalling and quiet NaNs of both signs in each operand position, against each other and against infinities and zeros, so that both the precedence and the unquieted pass-through are visible. The random phase forces the exponent field to all ones or all zeros on a share of vectors, so NaNs, infinities, zeros and subnormals keep appearing there too.

// File: rtl/fpmin_pkg.sv
// Package fpmin_pkg
// Shared operand classification used by the binary64 minimum unit.
// Assumes the classifier and the selector agree on this encoding only.
package fpmin_pkg;

    // Operand category derived from exponent and fraction fields
    typedef enum logic [2:0] {
        CLS_FINITE = 3'd0,
        CLS_ZERO   = 3'd1,
        CLS_INF    = 3'd2,
        CLS_QNAN   = 3'd3,
        CLS_SNAN   = 3'd4
    } fp_cls_e;

    // True for either NaN category
    function automatic logic cls_is_nan(input fp_cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fpmin_classify.sv
// Module fpmin_classify
// Sorts one floating-point encoding into zero, finite, infinity,
// quiet NaN or signalling NaN. The quiet bit is the top fraction bit.
// Subnormals are reported as finite. Purely combinational.
module fpmin_classify
    import fpmin_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [FP_W-1:0] op,
    output fp_cls_e         cls
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;
    logic              sign_unused;

    assign exp_f       = op[FP_W-2 -: EXP_W];
    assign frac_f      = op[FRAC_W-1:0];
    assign sign_unused = op[FP_W-1];

    // Field reductions feeding the category decision
    always_comb begin
        exp_ones  = &exp_f;
        exp_zero  = ~|exp_f;
        frac_zero = ~|frac_f;
    end

    // Category decision, NaN tested first
    always_comb begin
        if (exp_ones && !frac_zero)
            cls = frac_f[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        else if (exp_ones)
            cls = CLS_INF;
        else if (exp_zero && frac_zero)
            cls = CLS_ZERO;
        else
            cls = CLS_FINITE;
    end

endmodule

// File: rtl/fpmin_select.sv
// Module fpmin_select
// Chooses the minimum of two classified operands. A NaN in the first
// operand beats everything, a NaN in the second beats numbers. Opposite
// signed zeros give negative zero. Otherwise the sign-magnitude order is
// used, and ties take the second operand. NaNs pass through unmodified.
module fpmin_select
    import fpmin_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = 1 + EXP_W + FRAC_W,
    localparam int MAG_W = FP_W - 1
) (
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  fp_cls_e         cls_a,
    input  fp_cls_e         cls_b,
    output logic [FP_W-1:0] res,
    output logic            snan_seen
);

    localparam logic [FP_W-1:0] NEG_ZERO = {1'b1, {MAG_W{1'b0}}};

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             mag_a_lt, mag_a_gt;
    logic             a_below;
    logic             zero_pair;

    assign sgn_a = op_a[FP_W-1];
    assign sgn_b = op_b[FP_W-1];
    assign mag_a = op_a[MAG_W-1:0];
    assign mag_b = op_b[MAG_W-1:0];

    // Magnitude comparison shared by both sign cases
    always_comb begin
        mag_a_lt = mag_a < mag_b;
        mag_a_gt = mag_a > mag_b;
    end

    // Strict ordering of A below B for non-NaN operands
    always_comb begin
        if (sgn_a != sgn_b)
            a_below = sgn_a;
        else if (sgn_a)
            a_below = mag_a_gt;
        else
            a_below = mag_a_lt;
    end

    // Opposite-signed zero pair detection
    assign zero_pair = (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO) && (sgn_a != sgn_b);

    // Result mux in priority order
    always_comb begin
        if (cls_is_nan(cls_a))
            res = op_a;
        else if (cls_is_nan(cls_b))
            res = op_b;
        else if (zero_pair)
            res = NEG_ZERO;
        else if (a_below)
            res = op_a;
        else
            res = op_b;
    end

    // Invalid-operation indication for signalling inputs
    assign snan_seen = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);

endmodule

// File: rtl/fp_min_unit.sv
// Module fp_min_unit
// Single-stage binary64 minimum. Operands are the low doubleword of each
// vector input. The result is registered into the low doubleword with the
// upper part zero. Outputs load only when in_valid is high.
// Assumes a synchronous, active-low reset.
module fp_min_unit
    import fpmin_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = 1 + EXP_W + FRAC_W,
    localparam int HI_W  = VEC_W - FP_W,
    localparam int N_OPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             snan_flag
);

    logic [FP_W-1:0] ops [N_OPS];
    fp_cls_e         cls [N_OPS];
    logic [FP_W-1:0] sel_res;
    logic            sel_snan;
    logic            unused_hi;

    assign ops[0]    = src_a[FP_W-1:0];
    assign ops[1]    = src_b[FP_W-1:0];
    assign unused_hi = ^{src_a[VEC_W-1:FP_W], src_b[VEC_W-1:FP_W]};

    // One classifier per operand
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fpmin_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .op  (ops[gi]),
            .cls (cls[gi])
        );
    end

    fpmin_select #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_sel (
        .op_a      (ops[0]),
        .op_b      (ops[1]),
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .res       (sel_res),
        .snan_seen (sel_snan)
    );

    // Output stage: load on valid, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            snan_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= {{HI_W{1'b0}}, sel_res};
                snan_flag <= sel_snan;
            end
        end
    end

endmodule

// File: rtl/fpmin_chk.sv
// Module fpmin_chk
// Temporal checks on fp_min_unit ports, bound into every instance.
// Classifies the operands from raw fields on its own.
module fpmin_chk #(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             snan_flag
);

    logic a_nan, a_snan, b_snan, zpair;
    logic unused_chk;

    assign unused_chk = ^{src_a[VEC_W-1:FP_W], src_b[VEC_W-1:FP_W]};

    // Raw field tests on the operands
    always_comb begin
        a_nan  = (&src_a[FP_W-2:FRAC_W]) && (|src_a[FRAC_W-1:0]);
        a_snan = (&src_a[FP_W-2:FRAC_W]) && !src_a[FRAC_W-1] && (|src_a[FRAC_W-2:0]);
        b_snan = (&src_b[FP_W-2:FRAC_W]) && !src_b[FRAC_W-1] && (|src_b[FRAC_W-2:0]);
        zpair  = (src_a[FP_W-2:0] == '0) && (src_b[FP_W-2:0] == '0)
                 && (src_a[FP_W-1] != src_b[FP_W-1]);
    end

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result[VEC_W-1:FP_W] == '0);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(snan_flag)));

    // R5
    a_nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_nan) |=> (result[FP_W-1:0] == $past(src_a[FP_W-1:0])));

    // R7
    snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (snan_flag == $past(a_snan || b_snan)));

    // R8
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zpair) |=> (result[FP_W-1:0] == {1'b1, {(FP_W-1){1'b0}}}));

    // R9
    operand_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zpair) |=> (result[FP_W-1:0] == $past(src_a[FP_W-1:0])
                               || result[FP_W-1:0] == $past(src_b[FP_W-1:0])));

endmodule

bind fp_min_unit fpmin_chk #(
    .VEC_W  (VEC_W),
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_fpmin_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .snan_flag (snan_flag)
);

// File: tb/tb_fp_min_unit.sv
module tb_fp_min_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         snan_flag;

    int n_vec  = 0;
    int n_fail = 0;

    localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] NQNAN = 64'hFFF8_0000_0000_1234;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] NSNAN = 64'hFFF4_0000_0000_0000;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] SUB1  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] SUB2  = 64'h0000_0000_0000_0002;
    localparam logic [63:0] MSUB1 = 64'h8000_0000_0000_0001;
    localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;

    fp_min_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result),
        .snan_flag (snan_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic logic is_snan(input logic [63:0] v);
        return is_nan(v) && !v[51];
    endfunction

    // Total-order key: negatives flipped, positives offset above them
    function automatic logic [63:0] order_key(input logic [63:0] v);
        return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
    endfunction

    function automatic logic [63:0] ref_min(input logic [63:0] a, input logic [63:0] b);
        if (is_nan(a)) return a;
        if (is_nan(b)) return b;
        return (order_key(a) < order_key(b)) ? a : b;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one operand pair, then compare result and flag with the model
    task automatic run_pair(input string req, input logic [63:0] a, input logic [63:0] b,
                            input logic [63:0] hi_a = '0, input logic [63:0] hi_b = '0);
        @(negedge clk);
        in_valid = 1'b1;
        src_a    = {hi_a, a};
        src_b    = {hi_b, b};
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, {64'h0, ref_min(a, b)});
        check({req, " flag"}, {127'h0, snan_flag}, {127'h0, is_snan(a) || is_snan(b)});
        check({req, " valid"}, {127'h0, out_valid}, 128'h1);
    endtask

    task automatic t_reset;
        src_a    = {64'hFFFF_FFFF_FFFF_FFFF, ONE};
        src_b    = {64'hFFFF_FFFF_FFFF_FFFF, TWO};
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result", result, '0);
        check("R1 valid", {127'h0, out_valid}, '0);
        check("R1 flag", {127'h0, snan_flag}, '0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R2 idle valid", {127'h0, out_valid}, '0);
    endtask

    task automatic t_nan_a;
        run_pair("R5 qnan a vs one", QNAN, ONE);
        run_pair("R5 qnan a vs snan b", NQNAN, SNAN);
        run_pair("R5 snan a vs qnan b", SNAN, QNAN);
        run_pair("R5 snan a vs -inf", NSNAN, NINF);
    endtask

    task automatic t_nan_b;
        run_pair("R6 -inf vs qnan", NINF, NQNAN);
        run_pair("R6 -0 vs snan", NZERO, SNAN);
        run_pair("R6 sub vs neg snan", SUB1, NSNAN);
    endtask

    task automatic t_snan;
        run_pair("R7 snan both", SNAN, NSNAN);
        check("R7 unquieted", result, {64'h0, SNAN});
        run_pair("R7 qnan only no flag", ONE, QNAN);
        check("R7 no flag", {127'h0, snan_flag}, '0);
    endtask

    task automatic t_zeros;
        run_pair("R8 +0,-0", PZERO, NZERO);
        check("R8 value", result, {64'h0, NZERO});
        run_pair("R8 -0,+0", NZERO, PZERO);
        check("R8 value rev", result, {64'h0, NZERO});
    endtask

    task automatic t_signs;
        run_pair("R9 one vs -one", ONE, MONE);
        run_pair("R9 -sub vs +inf", MSUB1, PINF);
        run_pair("R9 +0 vs -sub", PZERO, MSUB1);
        run_pair("R9 -inf vs max", NINF, MAXF);
    endtask

    task automatic t_same_sign;
        run_pair("R10 pos", TWO, ONE);
        run_pair("R10 neg", MONE, MTWO);
        run_pair("R10 subnormals", SUB2, SUB1);
        run_pair("R10 max vs inf", PINF, MAXF);
        run_pair("R10 +0 vs sub", SUB1, PZERO);
    endtask

    task automatic t_equal;
        run_pair("R11 +inf pair", PINF, PINF);
        run_pair("R11 -inf pair", NINF, NINF);
        run_pair("R11 same", MONE, MONE);
    endtask

    task automatic t_upper;
        run_pair("R4 upper ignored", TWO, ONE, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R3 upper zero", {64'h0, result[127:64]}, '0);
        run_pair("R4 upper nan-like", ONE, TWO, QNAN, SNAN);
        check("R4 no flag", {127'h0, snan_flag}, '0);
    endtask

    task automatic t_hold;
        logic [127:0] prev;
        run_pair("R2 load", MTWO, ONE);
        prev = result;
        @(negedge clk);
        src_a = {64'h0, SNAN};
        src_b = {64'h0, NINF};
        @(negedge clk);
        check("R2 hold result", result, prev);
        check("R2 hold flag", {127'h0, snan_flag}, '0);
        check("R2 hold valid", {127'h0, out_valid}, '0);
    endtask

    function automatic logic [63:0] rand_fp();
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        case ($urandom_range(0, 3))
            0: v[62:52] = 11'h7FF;
            1: v[62:52] = 11'h000;
            default: ;
        endcase
        if ($urandom_range(0, 7) == 0) v[51:0] = '0;
        return v;
    endfunction

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            run_pair("R10 random", rand_fp(), rand_fp(), {$urandom(), $urandom()}, {$urandom(), $urandom()});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_nan_a();
        t_nan_b();
        t_snan();
        t_zeros();
        t_signs();
        t_same_sign();
        t_equal();
        t_upper();
        t_hold();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule